// File: doc/BRIEF.md
# Program Counter with Jump and Skip Control

This block keeps the code address of a small 8-bit controller. The address space is 15 bits, which gives 32K words. The counter moves forward by one on every completed instruction. It can instead take one of three jump forms:

- a long jump, which reloads the whole address;
- a short jump, which replaces only the low 12 bits and keeps the top three;
- a relative jump, which adds a small signed offset.

The upper seven bits go out separately as a page number. Accumulator-indexed table reads from code memory use that page.

Conditional instructions never branch. When a test fails, the decoder pulses a condition strobe with a false result. The block then marks the following instruction as squashed. That instruction is still fetched and still advances the counter, but its jump and condition inputs have no effect, and the mark clears once it retires. A decrement-and-skip operation uses the same path. The decoder reports "pass" while the register is still nonzero and "fail" when the register reaches zero.

Top module: `pc_seq`

## Requirements
- R1: After reset (`rst_n` low), `pc` is 0 and `squash` is 0.
- R2: While `advance` is 0, `pc` and `squash` keep their values and every other input is ignored.
- R3: With `advance` high, `squash` low and `jump_kind` = 0 (sequential), `pc` becomes `pc`+1 modulo 2^15 at the next edge.
- R4: With `jump_kind` = 1 (long), `pc` becomes `jump_target[14:0]`.
- R5: With `jump_kind` = 2 (short), `pc[11:0]` becomes `jump_target[11:0]` and `pc[14:12]` is kept.
- R6: With `jump_kind` = 3 (relative), `pc` becomes `pc` + `rel_off`, modulo 2^15. `rel_off` is a 7-bit two's-complement value and is legal from -31 to +32, except +1.
- R7: For a relative jump with an illegal offset (+1, below -31 or above +32), `illegal_rel` is 1 during that cycle and `pc` advances by one.
- R8: `advance` high with `squash` low, `cond_strobe` = 1 and `cond_pass` = 0 sets `squash` to 1 at the next edge. A passing or absent strobe leaves it 0.
- R9: An instruction retired while `squash` is 1 ignores `jump_kind`, `cond_strobe` and `rel_off`. For that instruction `illegal_rel` stays 0, `pc` advances by one and `squash` returns to 0.
- R10: `pc_page` always equals `pc[14:8]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| advance | input | 1 | Current instruction retires this cycle |
| jump_kind | input | 2 | 0 sequential, 1 long, 2 short, 3 relative |
| jump_target | input | 15 | Absolute target (low 12 bits for a short jump) |
| rel_off | input | 7 | Signed relative offset |
| cond_strobe | input | 1 | A test result is presented this cycle |
| cond_pass | input | 1 | Test outcome; 0 squashes the next instruction |
| pc | output | 15 | Current code address |
| pc_page | output | 7 | Upper seven address bits |
| squash | output | 1 | The current instruction is to be cancelled |
| illegal_rel | output | 1 | Relative offset outside the legal set |

## Verification
The bench drives jumps that cross the top of the address space in both directions, for long, relative and sequential steps. A design that does not wrap modulo 2^15, or that sign-extends the offset wrongly, lands on the wrong address. It also exercises the offset edges: -31 and +32 must be taken, while +1, +33 and -32 must only step by one and raise the flag. A design with an off-by-one range check either takes a forbidden jump or refuses a legal one. Squashed instructions carry a long jump, a failing condition and a +1 offset. A design that lets any of these through would jump, keep skipping every other instruction, or flag an instruction that never executed. A short jump from a high page shows whether the top three bits are kept rather than cleared.

// File: rtl/pc_seq.sv
module pc_seq #(
  parameter int AW      = 15,
  parameter int PAGE_W  = 7,
  parameter int SHORT_W = 12,
  parameter int OFF_W   = 7,
  parameter int REL_MIN = -31,
  parameter int REL_MAX = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    advance,
  input  logic [1:0]              jump_kind,
  input  logic [AW-1:0]           jump_target,
  input  logic signed [OFF_W-1:0] rel_off,
  input  logic                    cond_strobe,
  input  logic                    cond_pass,
  output logic [AW-1:0]           pc,
  output logic [PAGE_W-1:0]       pc_page,
  output logic                    squash,
  output logic                    illegal_rel
);
  localparam logic [1:0] K_SEQ = 2'd0, K_LONG = 2'd1, K_SHORT = 2'd2, K_REL = 2'd3;

  logic          skip_q;
  logic          rel_ok;
  logic [AW-1:0] pc_inc, rel_sum, pc_nx;

  assign rel_ok  = (int'(rel_off) >= REL_MIN) && (int'(rel_off) <= REL_MAX) && (int'(rel_off) != 1);
  assign pc_inc  = pc + {{(AW-1){1'b0}}, 1'b1};
  assign rel_sum = pc + {{(AW-OFF_W){rel_off[OFF_W-1]}}, rel_off};

  always_comb begin
    pc_nx = pc_inc;
    if (!skip_q) begin
      case (jump_kind)
        K_LONG:  pc_nx = jump_target;
        K_SHORT: pc_nx = {pc[AW-1:SHORT_W], jump_target[SHORT_W-1:0]};
        K_REL:   pc_nx = rel_ok ? rel_sum : pc_inc;
        default: pc_nx = pc_inc;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc     <= '0;
      skip_q <= 1'b0;
    end else if (advance) begin
      pc     <= pc_nx;
      skip_q <= !skip_q && cond_strobe && !cond_pass;
    end
  end

  assign pc_page     = pc[AW-1:AW-PAGE_W];
  assign squash      = skip_q;
  assign illegal_rel = advance && !skip_q && (jump_kind == K_REL) && !rel_ok;
endmodule

// File: rtl/pc_seq_chk.sv
module pc_seq_chk #(
  parameter int AW      = 15,
  parameter int PAGE_W  = 7,
  parameter int SHORT_W = 12,
  parameter int OFF_W   = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              advance,
  input logic [1:0]        jump_kind,
  input logic [AW-1:0]     jump_target,
  input logic [OFF_W-1:0]  rel_off,
  input logic              cond_strobe,
  input logic              cond_pass,
  input logic [AW-1:0]     pc,
  input logic [PAGE_W-1:0] pc_page,
  input logic              squash,
  input logic              illegal_rel
);
  localparam logic [AW-1:0] ONE = {{(AW-1){1'b0}}, 1'b1};

  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !advance |=> $stable(pc) && $stable(squash));

  a_r3_seq: assert property (@(posedge clk) disable iff (!rst_n)
    advance && !squash && jump_kind == 2'd0 |=> pc == $past(pc) + ONE);

  a_r4_long: assert property (@(posedge clk) disable iff (!rst_n)
    advance && !squash && jump_kind == 2'd1 |=> pc == $past(jump_target));

  a_r5_short: assert property (@(posedge clk) disable iff (!rst_n)
    advance && !squash && jump_kind == 2'd2 |=>
      pc[AW-1:SHORT_W] == $past(pc[AW-1:SHORT_W]) &&
      pc[SHORT_W-1:0] == $past(jump_target[SHORT_W-1:0]));

  a_r7_illegal_steps: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_rel |=> pc == $past(pc) + ONE);

  a_r8_skip_set: assert property (@(posedge clk) disable iff (!rst_n)
    advance && !squash && cond_strobe && !cond_pass |=> squash);

  a_r9_squash_clears: assert property (@(posedge clk) disable iff (!rst_n)
    advance && squash |=> !squash && pc == $past(pc) + ONE);

  a_r9_no_flag: assert property (@(posedge clk) disable iff (!rst_n)
    squash |-> !illegal_rel);
endmodule

bind pc_seq pc_seq_chk #(.AW(AW), .PAGE_W(PAGE_W), .SHORT_W(SHORT_W), .OFF_W(OFF_W)) u_chk (.*);

// File: tb/pc_seq_test.sv
module pc_seq_test;
  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              advance = 1'b0;
  logic [1:0]        jump_kind = 2'd0;
  logic [14:0]       jump_target = '0;
  logic signed [6:0] rel_off = '0;
  logic              cond_strobe = 1'b0;
  logic              cond_pass = 1'b0;
  logic [14:0]       pc;
  logic [6:0]        pc_page;
  logic              squash;
  logic              illegal_rel;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  pc_seq uut (.*);

  // kind, target, offset, strobe, pass, exp_ill, exp_pc, exp_sq
  localparam int NV = 22;
  localparam logic [42:0] VEC [0:NV-1] = '{
    {2'd0, 15'h0000, 7'd0,  1'b0, 1'b0, 1'b0, 15'h0001, 1'b0}, // R3
    {2'd0, 15'h0000, 7'd0,  1'b0, 1'b0, 1'b0, 15'h0002, 1'b0}, // R3
    {2'd1, 15'h7F00, 7'd0,  1'b0, 1'b0, 1'b0, 15'h7F00, 1'b0}, // R4
    {2'd0, 15'h0000, 7'd0,  1'b0, 1'b0, 1'b0, 15'h7F01, 1'b0}, // R3
    {2'd2, 15'h0ABC, 7'd0,  1'b0, 1'b0, 1'b0, 15'h7ABC, 1'b0}, // R5 keeps top bits
    {2'd3, 15'h0000, 7'd32, 1'b0, 1'b0, 1'b0, 15'h7ADC, 1'b0}, // R6 +32
    {2'd3, 15'h0000, 7'h61, 1'b0, 1'b0, 1'b0, 15'h7ABD, 1'b0}, // R6 -31
    {2'd3, 15'h0000, 7'd1,  1'b0, 1'b0, 1'b1, 15'h7ABE, 1'b0}, // R7 +1
    {2'd3, 15'h0000, 7'd33, 1'b0, 1'b0, 1'b1, 15'h7ABF, 1'b0}, // R7 +33
    {2'd3, 15'h0000, 7'h60, 1'b0, 1'b0, 1'b1, 15'h7AC0, 1'b0}, // R7 -32
    {2'd1, 15'h7FFE, 7'd0,  1'b0, 1'b0, 1'b0, 15'h7FFE, 1'b0}, // R4
    {2'd3, 15'h0000, 7'd5,  1'b0, 1'b0, 1'b0, 15'h0003, 1'b0}, // R6 wrap up
    {2'd3, 15'h0000, 7'h61, 1'b0, 1'b0, 1'b0, 15'h7FE4, 1'b0}, // R6 wrap down
    {2'd0, 15'h0000, 7'd0,  1'b1, 1'b0, 1'b0, 15'h7FE5, 1'b1}, // R8 fail
    {2'd1, 15'h1234, 7'd0,  1'b0, 1'b0, 1'b0, 15'h7FE6, 1'b0}, // R9 jump ignored
    {2'd0, 15'h0000, 7'd0,  1'b1, 1'b1, 1'b0, 15'h7FE7, 1'b0}, // R8 pass
    {2'd0, 15'h0000, 7'd0,  1'b1, 1'b0, 1'b0, 15'h7FE8, 1'b1}, // R8 fail
    {2'd3, 15'h0000, 7'd1,  1'b1, 1'b0, 1'b0, 15'h7FE9, 1'b0}, // R9 cond/flag ignored
    {2'd1, 15'h7FFF, 7'd0,  1'b0, 1'b0, 1'b0, 15'h7FFF, 1'b0}, // R4
    {2'd0, 15'h0000, 7'd0,  1'b0, 1'b0, 1'b0, 15'h0000, 1'b0}, // R3 wrap
    {2'd2, 15'h5FFF, 7'd0,  1'b0, 1'b0, 1'b0, 15'h0FFF, 1'b0}, // R5
    {2'd0, 15'h0000, 7'd0,  1'b0, 1'b0, 1'b0, 15'h1000, 1'b0}  // R3 carry
  };

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive(logic adv, logic [1:0] k, logic [14:0] t, logic [6:0] o, logic cs, logic cp);
    @(negedge clk);
    advance = adv; jump_kind = k; jump_target = t; rel_off = o;
    cond_strobe = cs; cond_pass = cp;
  endtask

  initial begin
    #1000000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    check("R1 pc", 32'(pc), 0);
    check("R1 squash", 32'(squash), 0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      logic [42:0] v;
      v = VEC[i];
      drive(1'b1, v[42:41], v[40:26], v[25:19], v[18], v[17]);
      #1;
      check("R7/R9 illegal_rel", 32'(illegal_rel), 32'(v[16]));
      @(posedge clk); #1;
      check("R3-6,R9 pc", 32'(pc), 32'(v[15:1]));
      check("R8/R9 squash", 32'(squash), 32'(v[0]));
      check("R10 page", 32'(pc_page), 32'(v[15:9]));
    end

    // R2: no advance, jump and failing test presented
    drive(1'b0, 2'd1, 15'h2222, 7'd0, 1'b1, 1'b0);
    @(posedge clk); #1;
    check("R2 pc held", 32'(pc), 32'h1000);
    check("R2 squash held", 32'(squash), 0);

    // R2: squash held across stalls
    drive(1'b1, 2'd0, 15'h0, 7'd0, 1'b1, 1'b0);
    @(posedge clk); #1;
    check("R8 squash set", 32'(squash), 1);
    drive(1'b0, 2'd3, 15'h0, 7'd4, 1'b0, 1'b0);
    @(posedge clk); #1;
    check("R2 squash kept", 32'(squash), 1);
    check("R2 pc kept", 32'(pc), 32'h1001);

    // R1: reset while squash pending
    @(negedge clk); rst_n = 1'b0; #1;
    check("R1 pc after reset", 32'(pc), 0);
    check("R1 squash after reset", 32'(squash), 0);
    @(negedge clk); rst_n = 1'b1;
    drive(1'b1, 2'd1, 15'h4321, 7'd0, 1'b0, 1'b0);
    @(posedge clk); #1;
    check("R4 jump after reset", 32'(pc), 32'h4321);
    check("R10 page after jump", 32'(pc_page), 32'h43);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule